// File: doc/BRIEF.md
# Read ODT Scheduler

This controller-side block drives the on-die-termination enable pin of a DDR3-class DRAM around read bursts. The command scheduler reports each READ it puts on the bus with a one-cycle strobe. Static configuration supplies the CAS latency, the additive latency and the CAS write latency. From these three values the block derives the read latency and the termination switching latency. It then pulls the termination enable low early enough that the device termination is already off half a cycle before the read preamble. It keeps the pin low until termination, even at its fastest turn-on, can only come back after the read postamble.

While no read window is open, the pin follows an idle request from the rest of the controller, one cycle later. Each READ opens a window slot that counts down. Reads that overlap merge into one continuous low window. When the arithmetic leaves no lead time between the READ and the latest turn-off point, the pin must already have been low for long enough before the READ. A ready output tells the scheduler whether a READ issued in the current cycle would meet that deadline, and whether a free window slot exists.

Top module: `rodt_read_scheduler`

## Requirements
- R1: `rd_lat_o` equals CL + AL, and `odt_lat_o` equals CWL + AL - 2, where CL = `cfg_cl_i`, AL = `cfg_al_i` and CWL = `cfg_cwl_i`, all unsigned.
- R2: While `rst_ni` is low, and in the first cycle after its release, `odt_o` is 0.
- R3: With no read window open, `odt_o` in cycle c equals `odt_req_i` sampled in cycle c-1.
- R4: A READ strobed in cycle t forces `odt_o` to 0 in cycles t+1 through t+W, where W = RL + 3 - ODTL = CL - CWL + 5. From cycle t+W+1, `odt_o` follows R3 again if no other window covers that cycle.
- R5: Overlapping READs merge their windows. `odt_o` stays 0 from one cycle after the first READ until W cycles after the last READ, with no gap.
- R6: When the lead L = RL - ODTL - 2 is at least 1, `rd_ready_o` is 1 whenever a window slot is free, whatever the level of `odt_o`.
- R7: When L is 0 or less, `rd_ready_o` is 1 only if `odt_o` has been 0 for at least 1 - L consecutive cycles, counting the current one, and a slot is free.
- R8: At most NUM_SLOTS windows (default 4) may be open at once. A slot opens at the edge after its READ and frees in cycle t+W+1. When all slots are open, `rd_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_cl_i | input | 5 | CAS latency in cycles |
| cfg_al_i | input | 5 | Additive latency in cycles |
| cfg_cwl_i | input | 5 | CAS write latency in cycles |
| odt_req_i | input | 1 | Idle termination request from the rest of the controller |
| rd_issue_i | input | 1 | One-cycle strobe: a READ is on the command bus this cycle |
| odt_o | output | 1 | Termination enable pin toward the DRAM |
| rd_ready_o | output | 1 | A READ issued this cycle would meet the turn-off deadline |
| rd_lat_o | output | 7 | Derived read latency |
| odt_lat_o | output | 7 | Derived termination switching latency |

## Verification
The assertions assume that `rd_issue_i` is only asserted while `rd_ready_o` is high, and that the configuration stays fixed outside reset. They also assume CL is at least CWL - 2 and CWL + AL is at least 2, so the window length is positive and the lead requirement stays small. The bench loads each configuration while reset is held, filters the sweep to that latency range, and gates every READ attempt with its own arithmetic prediction of readiness. As a result, a READ is never strobed against a busy or late state.

// File: rtl/rodt_pkg.sv
package rodt_pkg;
  localparam int unsigned CFG_W     = 5;
  localparam int unsigned LAT_W     = CFG_W + 2;
  localparam int unsigned BURST_CYC = 4;  // BL8 occupies four clocks

  typedef logic [CFG_W-1:0]      cfg_t;
  typedef logic [LAT_W-1:0]      lat_t;
  typedef logic signed [LAT_W:0] slat_t;
endpackage

// File: rtl/rodt_lat_calc.sv
module rodt_lat_calc
  import rodt_pkg::*;
(
  input  cfg_t cl_i,
  input  cfg_t al_i,
  input  cfg_t cwl_i,
  output lat_t rd_lat_o,
  output lat_t odt_lat_o,
  output lat_t win_o,
  output lat_t need_o,
  output logic lead_pos_o
);
  lat_t  rl, odtl;
  slat_t lead, need_s;

  always_comb begin
    rl     = lat_t'(cl_i) + lat_t'(al_i);
    odtl   = lat_t'(cwl_i) + lat_t'(al_i) - lat_t'(2);
    // cycles between READ and the last legal ODT-low sample
    lead   = $signed({1'b0, rl}) - $signed({1'b0, odtl}) - slat_t'(2);
    need_s = slat_t'(1) - lead;
    lead_pos_o = (lead > slat_t'(0));
    need_o     = lead_pos_o ? '0 : need_s[LAT_W-1:0];
    // low through RL+3-ODTL, high allowed at RL+4-ODTL
    win_o      = rl + lat_t'(BURST_CYC - 1) - odtl;
    rd_lat_o   = rl;
    odt_lat_o  = odtl;
  end
endmodule

// File: rtl/rodt_window.sv
module rodt_window
  import rodt_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  lat_t win_i,
  output logic busy_o,
  output logic full_o
);
  logic [NUM_SLOTS-1:0] free, alloc;

  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      alloc[i] = free[i] & ~taken & issue_i;
      taken    = taken | free[i];
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    lat_t cnt_q;
    assign free[g] = (cnt_q == '0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (alloc[g]) cnt_q <= win_i;
      else if (!free[g]) cnt_q <= cnt_q - lat_t'(1);
    end
  end

  assign busy_o = ~&free;
  assign full_o = ~|free;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !full_o); // R8
  AST_WIN_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && (win_i != '0) |=> busy_o); // R4
endmodule

// File: rtl/rodt_ready.sv
module rodt_ready
  import rodt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic odt_i,
  input  logic lead_pos_i,
  input  lat_t need_i,
  input  logic full_i,
  output logic ready_o
);
  lat_t run_q, run_now;

  always_comb begin
    if (odt_i)              run_now = '0;
    else if (run_q == '1)   run_now = run_q;
    else                    run_now = run_q + lat_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_now;
  end

  assign ready_o = !full_i && (lead_pos_i || (run_now >= need_i));

  AST_LATE_READ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !lead_pos_i |-> !odt_i); // R7
  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> !ready_o); // R8
endmodule

// File: rtl/rodt_read_scheduler.sv
module rodt_read_scheduler
  import rodt_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_cl_i,
  input  logic [CFG_W-1:0] cfg_al_i,
  input  logic [CFG_W-1:0] cfg_cwl_i,
  input  logic             odt_req_i,
  input  logic             rd_issue_i,
  output logic             odt_o,
  output logic             rd_ready_o,
  output logic [LAT_W-1:0] rd_lat_o,
  output logic [LAT_W-1:0] odt_lat_o
);
  lat_t win, need;
  logic lead_pos, busy, full, req_q;

  rodt_lat_calc i_calc (
    .cl_i       (cfg_cl_i),
    .al_i       (cfg_al_i),
    .cwl_i      (cfg_cwl_i),
    .rd_lat_o   (rd_lat_o),
    .odt_lat_o  (odt_lat_o),
    .win_o      (win),
    .need_o     (need),
    .lead_pos_o (lead_pos)
  );

  rodt_window #(.NUM_SLOTS(NUM_SLOTS)) i_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (rd_issue_i),
    .win_i   (win),
    .busy_o  (busy),
    .full_o  (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= odt_req_i;
  end

  assign odt_o = req_q & ~busy;

  rodt_ready i_ready (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .odt_i      (odt_o),
    .lead_pos_i (lead_pos),
    .need_i     (need),
    .full_i     (full),
    .ready_o    (rd_ready_o)
  );

  AST_ISSUE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_issue_i |-> rd_ready_o); // R6
  AST_READ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_issue_i |=> !odt_o); // R4
  AST_REQ_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odt_o |-> $past(odt_req_i)); // R3
endmodule

// File: tb/test_rodt_read_scheduler.sv
`timescale 1ns/1ps
module test_rodt_read_scheduler;
  import rodt_pkg::*;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  cfg_t cl, al, cwl;
  logic req = 1'b0, iss = 1'b0;
  logic odt, rdy;
  lat_t rl_o, odtl_o;

  always #2 clk = ~clk;

  rodt_read_scheduler #(.NUM_SLOTS(NS)) i_rodt_read_scheduler (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_cl_i(cl), .cfg_al_i(al), .cfg_cwl_i(cwl),
    .odt_req_i(req), .rd_issue_i(iss), .odt_o(odt), .rd_ready_o(rdy),
    .rd_lat_o(rl_o), .odt_lat_o(odtl_o)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  int cyc, lead_m, win_m, need_m, run_m, last_iss;
  bit have_iss, req_d1, sent;
  int q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s cyc=%0d cl=%0d al=%0d cwl=%0d act=%0d exp=%0d",
               tag, cyc, cl, al, cwl, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic cycle(input bit r, input bit want);
    bit exp_odt, exp_rdy, in_win;
    int outst;
    @(negedge clk);
    while (q.size() > 0 && q[0] + win_m < cyc) void'(q.pop_front());
    outst = 0;
    foreach (q[i]) if (cyc <= q[i] + win_m) outst++;
    in_win  = have_iss && (cyc <= last_iss + win_m);
    exp_odt = req_d1 && !in_win;
    run_m   = exp_odt ? 0 : run_m + 1;
    exp_rdy = (outst < NS) && (lead_m > 0 || run_m >= need_m);
    if (in_win) chk(odt == exp_odt, outst > 1 ? "R5" : "R4", odt, exp_odt);
    else        chk(odt == exp_odt, "R3", odt, exp_odt);
    if (outst >= NS)     chk(rdy == exp_rdy, "R8", rdy, exp_rdy);
    else if (lead_m > 0) chk(rdy == exp_rdy, "R6", rdy, exp_rdy);
    else                 chk(rdy == exp_rdy, "R7", rdy, exp_rdy);
    req  = r;
    iss  = want && exp_rdy;
    sent = iss;
    if (iss) begin
      q.push_back(cyc);
      have_iss = 1;
      last_iss = cyc;
    end
    req_d1 = r;
    cyc++;
  endtask

  task automatic issue_one(input bit r);
    for (int n = 0; n < 20; n++) begin
      cycle(r, 1);
      if (sent) break;
    end
  endtask

  task automatic run_cfg(input int c, input int a, input int w);
    bit hi;
    @(negedge clk);
    rst_ni = 0; req = 0; iss = 0;
    cl = cfg_t'(c); al = cfg_t'(a); cwl = cfg_t'(w);
    repeat (2) @(negedge clk);
    chk(odt == 1'b0, "R2", odt, 0);
    chk(rl_o == lat_t'(c + a), "R1", rl_o, c + a);
    chk(odtl_o == lat_t'(w + a - 2), "R1", odtl_o, w + a - 2);
    lead_m = c - w;
    win_m  = lead_m + 5;
    need_m = lead_m > 0 ? 0 : 1 - lead_m;
    hi     = lead_m > 0;
    cyc = 0; q.delete(); have_iss = 0; req_d1 = 0;
    run_m = 1;  // low half-cycle between release and first edge
    rst_ni = 1;
    cycle(1, 0);  // first cycle after release: R2 via generic check
    repeat (3) cycle(1, 0);
    cycle(0, 0); cycle(1, 0); cycle(0, 0); cycle(1, 0);
    // single read, then reassert
    issue_one(hi);
    repeat (win_m + 3) cycle(1, 0);
    // merging reads
    issue_one(hi);
    cycle(hi, 0);
    issue_one(hi);
    repeat (3) cycle(hi, 0);
    issue_one(hi);
    repeat (win_m + 3) cycle(1, 0);
    // slot exhaustion
    repeat (2 * win_m + 4) cycle(hi, 1);
    repeat (win_m + 3) cycle(1, 0);
    // low-run buildup for ready
    repeat (need_m + 3) cycle(0, 0);
    repeat (3) cycle(1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int c = 5; c <= 10; c++)
      for (int w = 5; w <= 8; w++)
        for (int ai = 0; ai < 3; ai++) begin
          if (c + 2 < w) continue;
          run_cfg(c, ai == 0 ? 0 : (ai == 1 ? 1 : c - 2), w);
        end
    finish_run();
  end
endmodule